// File: doc/BRIEF.md
# Reader Receive Frame Decoder

This block sits behind the demodulator of a tag reader and turns a recovered baseband level stream into checked bytes for the host microcontroller. The line is sampled once per system clock. A correlator compares the most recent samples against a fixed header shape. Only a complete header match starts a frame. From that point the decoder reads FM0 symbols at fixed offsets inside each bit period.

Decoded bits are packed into bytes, most significant bit first, and written into a small byte FIFO. A CRC-16 register takes in the same bits. When the frame ends, the controller judges it. A good frame is released to the host without its two CRC bytes, and a one-cycle ready pulse is raised. A bad frame is rolled back out of the FIFO and a one-cycle error pulse is raised instead. Bytes from earlier good frames that the host has not yet read are kept.

Top module: `rx_frame_decoder`

## Requirements
- R1: After reset, rd_valid, frame_ok, frame_err and busy are all 0.
- R2: busy rises only after the full header has been seen on rx_in. The header is 12 half-bit levels, sent first to last as 1,1,1,0,1,0,0,0,1,1,0,1, and each half lasts OSR/2 clocks. FM0 activity without a header produces no pulse, no readable byte and no busy.
- R3: Each bit lasts OSR clocks, and the level inverts at every bit boundary. A bit with a level change at mid-bit decodes as 0, and a bit without one decodes as 1. Bits are packed into bytes MSB first.
- R4: A bit whose first half has the same level as the previous half-bit ends the frame.
- R5: A frame passes when it is a whole number of bytes, has at least 3 bytes, and leaves the CRC register at 0x0000. The CRC uses polynomial 0x1021 and a start value of 0xFFFF, and covers all bytes, including the CRC high byte and then the low byte sent last. A passing frame gives one frame_ok pulse, and its bytes, without the two CRC bytes, become readable in order through rd_data/rd_valid/rd_en.
- R6: A failing frame gives one frame_err pulse and adds no readable byte. Bytes already released and not yet read stay readable and unchanged.
- R7: A frame with a trailing partial byte, or with fewer than 3 bytes, fails.
- R8: When MAX_BYTES (default 12) bytes have been decoded, the frame ends without waiting for a missing transition. Any further line activity is ignored until the next header.
- R9: If a byte arrives while the FIFO (DEPTH 16) is full, the byte is dropped and the frame fails.
- R10: frame_ok and frame_err are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Demodulated baseband level |
| rd_en | input | 1 | Host pops the byte on rd_data |
| rd_data | output | 8 | Oldest released byte |
| rd_valid | output | 1 | A released byte is available |
| frame_ok | output | 1 | One-cycle pulse: checked frame released |
| frame_err | output | 1 | One-cycle pulse: frame discarded |
| busy | output | 1 | A frame is being decoded |

## Verification
The bench drives a header-free FM0 stream. A decoder that was not gated by the header would report frames from it. It sends a 12-byte frame followed by a stray byte. A decoder that ignored the length limit would fold the stray byte into the CRC and fail the frame. It sends a bad frame while a good frame is still unread. A rollback to the wrong pointer would either corrupt the unread frame or leak the bad one. It also sends a frame that overfills the FIFO. A design that wrapped the write pointer would overwrite unread data. Frames with a trailing partial byte or only two bytes must fail; a check on the CRC alone would pass them.

// File: rtl/rx_frame_decoder.sv
module rx_frame_decoder #(
  parameter int          OSR         = 8,
  parameter int          HDR_HALVES  = 12,
  parameter logic [11:0] HDR_PAT     = 12'b1110_1000_1101,
  parameter int          DEPTH       = 16,
  parameter int          MAX_BYTES   = 12,
  parameter logic [15:0] CRC_POLY    = 16'h1021,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'h0000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       frame_ok,
  output logic       frame_err,
  output logic       busy
);
  localparam int H   = OSR / 2;
  localparam int SW  = HDR_HALVES * H;
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int CW  = $clog2(OSR);
  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam logic [CW-1:0] T_FIRST  = CW'(H / 2);
  localparam logic [CW-1:0] T_SECOND = CW'(H + H / 2);
  localparam logic [CW-1:0] T_LAST   = CW'(OSR - 1);

  typedef enum logic [1:0] {S_HUNT, S_DATA, S_END} st_t;
  st_t state;

  logic [SW-1:0]  sh, hdr_exp;
  logic [CW-1:0]  cnt;
  logic           prev_half, first_half;
  logic [15:0]    crc, crc_next;
  logic [6:0]     acc;
  logic [2:0]     nbits;
  logic [BCW-1:0] nbytes;
  logic           ovf;
  logic [PW-1:0]  wr_ptr, rd_ptr, commit_ptr;
  logic [7:0]     mem [DEPTH];

  for (genvar i = 0; i < SW; i++) begin : g_hdr
    assign hdr_exp[i] = HDR_PAT[i / H];
  end

  wire hdr_hit   = (sh == hdr_exp);
  wire bit_val   = (first_half == sh[0]);
  wire fb        = crc[15] ^ bit_val;
  assign crc_next = {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  wire decide    = (state == S_DATA) && (cnt == T_SECOND);
  wire byte_done = decide && (nbits == 3'd7);
  wire full      = (PW'(wr_ptr - rd_ptr) == PW'(DEPTH));
  wire good      = !ovf && (nbits == 3'd0) && (nbytes >= BCW'(3)) && (crc == CRC_RESIDUE);
  wire rd_pop    = rd_en && rd_valid;

  assign rd_valid = (rd_ptr != commit_ptr);
  assign rd_data  = mem[rd_ptr[AW-1:0]];
  assign busy     = (state != S_HUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SW-2:0], rx_in};
  end

  always_ff @(posedge clk) begin
    if (byte_done && !full) mem[wr_ptr[AW-1:0]] <= {acc, bit_val};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_HUNT;
      cnt        <= '0;
      prev_half  <= 1'b0;
      first_half <= 1'b0;
      crc        <= CRC_INIT;
      acc        <= '0;
      nbits      <= '0;
      nbytes     <= '0;
      ovf        <= 1'b0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      commit_ptr <= '0;
      frame_ok   <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
      if (rd_pop) rd_ptr <= rd_ptr + PW'(1);
      case (state)
        S_HUNT: begin
          if (hdr_hit) begin
            state     <= S_DATA;
            cnt       <= '0;
            prev_half <= HDR_PAT[0];
            crc       <= CRC_INIT;
            nbits     <= '0;
            nbytes    <= '0;
            ovf       <= 1'b0;
          end
        end
        S_DATA: begin
          cnt <= (cnt == T_LAST) ? '0 : cnt + CW'(1);
          if (cnt == T_FIRST) begin
            first_half <= sh[0];
            if (sh[0] == prev_half) state <= S_END;
          end
          if (decide) begin
            prev_half <= sh[0];
            crc       <= crc_next;
            acc       <= {acc[5:0], bit_val};
            if (nbits == 3'd7) begin
              nbits  <= '0;
              nbytes <= nbytes + BCW'(1);
              if (full) ovf <= 1'b1;
              else      wr_ptr <= wr_ptr + PW'(1);
              if (nbytes + BCW'(1) == BCW'(MAX_BYTES)) state <= S_END;
            end else begin
              nbits <= nbits + 3'd1;
            end
          end
        end
        default: begin
          state <= S_HUNT;
          if (good) begin
            commit_ptr <= wr_ptr - PW'(2);
            wr_ptr     <= wr_ptr - PW'(2);
            frame_ok   <= 1'b1;
          end else begin
            wr_ptr    <= commit_ptr;
            frame_err <= 1'b1;
          end
        end
      endcase
    end
  end

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_err));
  a_r10_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);
  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  a_r2_busy_after_header: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hdr_hit));
  a_r5_ok_releases: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (commit_ptr != $past(commit_ptr)));
  a_r6_err_keeps_release: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(commit_ptr));
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(wr_ptr - rd_ptr) <= PW'(DEPTH));
  a_r4_end_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_END) |-> ($past(state) == S_DATA));
endmodule

// File: tb/tb_rx_frame_decoder.sv
module tb_rx_frame_decoder;
  localparam int OSR = 8;
  localparam int H = OSR / 2;
  localparam logic [11:0] HDR = 12'b1110_1000_1101;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, frame_ok, frame_err, busy;

  rx_frame_decoder dut (.clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .frame_ok(frame_ok),
    .frame_err(frame_err), .busy(busy));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, ok_cnt = 0, err_cnt = 0;
  logic lvl = 1'b0;
  logic [7:0] pay [16];
  logic [7:0] keep [16];

  always @(negedge clk) if (rst_n) begin
    if (frame_ok) ok_cnt++;
    if (frame_err) err_cnt++;
    if (frame_ok && frame_err) begin
      errors++; $display("FAIL R10 ok=%0d err=%0d expected not both", frame_ok, frame_err);
    end
  end

  task automatic check(input bit cond, input string tag, input int act, input int expv);
    checks++;
    if (!cond) begin errors++; $display("FAIL %s actual=%0h expected=%0h", tag, act, expv); end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic f = r[15] ^ b[i];
      r = {r[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic half(input logic v);
    repeat (H) begin @(negedge clk); rx_in = v; end
  endtask
  task automatic send_bit(input logic b);
    lvl = ~lvl; half(lvl);
    if (!b) lvl = ~lvl;
    half(lvl);
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic send_hdr();
    for (int i = 11; i >= 0; i--) half(HDR[i]);
    lvl = HDR[0];
  endtask
  task automatic send_tail();
    half(lvl); half(lvl);
    lvl = 1'b0;
    repeat (8) half(1'b0);
  endtask

  task automatic send_frame(input int n, input bit corrupt, input int extra,
                            input bit want_ok, input string tag);
    logic [15:0] c = 16'hFFFF;
    int ok0 = ok_cnt, er0 = err_cnt;
    for (int i = 0; i < n; i++) c = crc_upd(c, pay[i]);
    if (corrupt) c[3] = ~c[3];
    send_hdr();
    for (int i = 0; i < n; i++) send_byte(pay[i]);
    send_byte(c[15:8]); send_byte(c[7:0]);
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    send_tail();
    check(ok_cnt - ok0 == (want_ok ? 1 : 0), {tag, " frame_ok count"}, ok_cnt - ok0, want_ok ? 1 : 0);
    check(err_cnt - er0 == (want_ok ? 0 : 1), {tag, " frame_err count"}, err_cnt - er0, want_ok ? 0 : 1);
  endtask

  task automatic read_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 1'b0;
      check(rd_valid === 1'b1, {tag, " rd_valid"}, rd_valid, 1);
      check(rd_data === keep[i], {tag, " rd_data"}, rd_data, keep[i]);
      rd_en = 1'b1;
    end
    @(negedge clk); rd_en = 1'b0;
    check(rd_valid === 1'b0, {tag, " fifo drained"}, rd_valid, 0);
  endtask

  task automatic copy_keep(input int n);
    for (int i = 0; i < n; i++) keep[i] = pay[i];
  endtask

  initial begin
    int n, busy_seen;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    check(!rd_valid && !frame_ok && !frame_err && !busy, "R1 reset outputs", {rd_valid, frame_ok, frame_err, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rd_valid && !busy, "R1 after release", {rd_valid, busy}, 0);

    busy_seen = 0;
    for (int i = 0; i < 40; i++) begin send_bit(1'($urandom)); if (busy) busy_seen++; end
    send_tail();
    check(busy_seen == 0, "R2 no header busy", busy_seen, 0);
    check(ok_cnt == 0 && err_cnt == 0, "R2 no header pulses", ok_cnt + err_cnt, 0);
    check(!rd_valid, "R2 no header data", rd_valid, 0);

    pay[0] = 8'h00; pay[1] = 8'hFF; pay[2] = 8'hA5;
    send_frame(3, 0, 0, 1, "R3 R5 directed");
    copy_keep(3); read_check(3, "R3 bits 00 FF A5");

    for (int f = 0; f < 8; f++) begin
      n = 1 + int'($urandom % 10);
      for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
      send_frame(n, 0, 0, 1, "R5 random");
      copy_keep(n); read_check(n, "R5 random payload");
    end

    for (int i = 0; i < 4; i++) pay[i] = 8'($urandom);
    send_frame(4, 0, 0, 1, "R6 first good");
    copy_keep(4);
    for (int i = 0; i < 5; i++) pay[i] = 8'($urandom);
    send_frame(5, 1, 0, 0, "R6 bad crc");
    read_check(4, "R6 prior frame intact");

    for (int i = 0; i < 2; i++) pay[i] = 8'($urandom);
    send_frame(2, 0, 3, 0, "R7 partial byte");
    send_frame(0, 0, 0, 0, "R7 too short");
    check(!rd_valid, "R7 nothing released", rd_valid, 0);

    for (int i = 0; i < 10; i++) pay[i] = 8'($urandom);
    send_frame(10, 0, 8, 1, "R8 length limit");
    copy_keep(10); read_check(10, "R8 payload");

    for (int i = 0; i < 10; i++) pay[i] = 8'($urandom);
    send_frame(10, 0, 0, 1, "R9 fill");
    copy_keep(10);
    for (int i = 0; i < 5; i++) pay[i] = 8'($urandom);
    send_frame(5, 0, 0, 0, "R9 overflow");
    read_check(10, "R9 unread data intact");

    busy_seen = 0;
    pay[0] = 8'h3C;
    fork
      send_frame(1, 0, 0, 1, "R4 end by missing transition");
      begin
        repeat (12 * H + 4) @(negedge clk);
        if (busy) busy_seen = 1;
      end
    join
    check(busy_seen == 1, "R2 busy after header", busy_seen, 1);
    check(!busy, "R4 idle after end", busy, 0);
    copy_keep(1); read_check(1, "R4 payload");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule